// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is a single countdown timer reached through a small synchronous register bus: a word address, a write strobe, write data and registered read data. Software sets a reload value, picks a mode and a counter size, chooses a clock prescale of 1, 16 or 256, and enables counting. Each time the counter runs down to zero the block raises a sticky raw interrupt flag. A level interrupt line reports that flag whenever the interrupt-enable bit allows it.

There are three counting modes. Periodic mode reloads from the stored value. One-shot mode stops at zero after its first expiry. Free-running mode ignores the stored value and wraps at the full counter size. The reload value can be written in two ways: an immediate write that also restarts the count, or a background write that takes effect only at the next natural reload. Software can read both the raw and the masked interrupt status.

Top module: `cdt_timer`

## Requirements
- R1: Reads at word offset 0 and at word offset 6 both return the stored reload value. Offset 1 returns the current count. Offset 2 returns the control byte in bits 7:0 with zeros above. Offset 4 returns the raw flag in bit 0. Offset 5 returns the masked flag in bit 0. Reads of offset 3 and of offsets 7 and above return 0. Writes to offsets 7 and above change nothing.
- R2: After reset, the control byte reads 0x20, the count reads 0xFFFF, the stored reload value reads 0, the raw flag reads 0 and the interrupt line is low.
- R3: The current-count register at offset 1 is read-only. A write to it leaves the count unchanged.
- R4: A write to offset 0 stores the value and, at the same edge, loads the counter with the active reload value.
- R5: A write to offset 6 stores the value without touching the count. The new value is used at the next reload.
- R6: While enabled, the count drops by one on each prescaled tick. On the tick that takes it from 1 to 0 the raw flag sets. On the next tick the counter reloads. With reload value N and a prescale of 1, the first expiry comes N cycles after the enabling write, and later expiries come every N+1 cycles.
- R7: With control bit 0 (one-shot) set, the counter stays at 0 after its first expiry and raises no further interrupts.
- R8: With control bits 6 (periodic) and 0 both clear, the timer runs free. Its reload value is 0xFFFF when bit 1 is 0 (16-bit size) and 0xFFFFFFFF when bit 1 is 1 (32-bit size), and the stored value is not used. In 16-bit size the count reads with its upper 16 bits zero.
- R9: Control bits 3:2 set the prescale: 0 divides by 1, 1 by 16, 2 by 256, and 3 divides by 1. A control write that changes this field restarts the prescale phase, so the first tick comes 16 or 256 cycles after that write.
- R10: The interrupt line equals the raw flag ANDed with control bit 5 (interrupt enable). It is registered and follows the raw flag and the enable bit at the same edge they change. The masked status reads 0 while bit 5 is clear.
- R11: Any write to offset 3 clears the raw flag. If an expiry happens in the same cycle, the flag stays set.
- R12: While control bit 7 (enable) is clear, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | AW (4) | Word offset of the register |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, registered, for the offset presented in the previous cycle |
| irq_o | output | 1 | Level interrupt, raw flag gated by the interrupt enable |

## Verification
A wrong prescale phase or a wrong reload value does not stay hidden. It moves the first rising edge of `irq_o` away from its arithmetic slot: N, 16N or 256N cycles after the enabling write. The next period, N+1 cycles, exposes it again. A count that slips by one shows up in the next read of offset 1, one cycle after the address is presented, or at the next expiry. A raw flag that sticks or is lost shows on `irq_o` in the cycle after a clear or an expiry, so the bench watches that line cycle by cycle.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  // Control byte, most significant bit first.
  typedef struct packed {
    logic       en;        // bit 7: counting enabled
    logic       periodic;  // bit 6: periodic reload
    logic       ie;        // bit 5: interrupt enable
    logic       spare;     // bit 4: stored, no function
    logic [1:0] pre;       // bits 3:2: prescale select
    logic       wide;      // bit 1: 32-bit counter size
    logic       oneshot;   // bit 0: stop after first expiry
  } cdt_ctrl_t;

  typedef enum logic [1:0] {
    PRE_DIV1   = 2'd0,
    PRE_DIV16  = 2'd1,
    PRE_DIV256 = 2'd2,
    PRE_ALT1   = 2'd3
  } cdt_pre_e;

  localparam logic [7:0] CTRL_RESET = 8'h20;

  localparam int OFS_LOAD  = 0;
  localparam int OFS_VALUE = 1;
  localparam int OFS_CTRL  = 2;
  localparam int OFS_CLR   = 3;
  localparam int OFS_RAW   = 4;
  localparam int OFS_MASK  = 5;
  localparam int OFS_BGLD  = 6;

endpackage

// File: rtl/cdt_prescaler.sv
module cdt_prescaler
  import cdt_pkg::*;
#(
  parameter int PRE_W = 8,   // full divide = 2**PRE_W
  parameter int MID_W = 4    // middle divide = 2**MID_W
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       tick
);

  logic [PRE_W-1:0] phase_q;
  logic             tap_mid;
  logic             tap_full;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  generate
    if (MID_W > 0) begin : g_mid
      assign tap_mid = &phase_q[MID_W-1:0];
    end else begin : g_nomid
      assign tap_mid = 1'b1;
    end
  endgenerate

  assign tap_full = &phase_q;

  always_comb begin
    unique case (cdt_pre_e'(sel))
      PRE_DIV16:  tick = tap_mid;
      PRE_DIV256: tick = tap_full;
      default:    tick = 1'b1;
    endcase
  end

endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int DW = 32,
  parameter int NW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          periodic,
  input  logic          oneshot,
  input  logic          wide,
  input  logic          tick,
  input  logic          load_now,
  input  logic [DW-1:0] load_data,
  input  logic [DW-1:0] load_val,
  output logic [DW-1:0] count_eff,
  output logic          expire
);

  localparam logic [DW-1:0] FULL_MASK   = '1;
  localparam logic [DW-1:0] NARROW_MASK = {{(DW-NW){1'b0}}, {NW{1'b1}}};
  localparam logic [DW-1:0] ONE         = {{(DW-1){1'b0}}, 1'b1};

  logic [DW-1:0] count_q;
  logic [DW-1:0] size_mask;
  logic          free_run;
  logic [DW-1:0] reload_bg;
  logic [DW-1:0] reload_now;
  logic          at_zero;

  assign size_mask  = wide ? FULL_MASK : NARROW_MASK;
  assign free_run   = !periodic && !oneshot;
  assign count_eff  = count_q & size_mask;
  assign at_zero    = (count_eff == '0);
  assign reload_bg  = free_run ? size_mask : (load_val & size_mask);
  assign reload_now = free_run ? size_mask : (load_data & size_mask);
  assign expire     = en && tick && !load_now && (count_eff == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= FULL_MASK;
    end else if (load_now) begin
      count_q <= reload_now;
    end else if (en && tick) begin
      if (at_zero) begin
        if (!oneshot) begin
          count_q <= reload_bg;
        end
      end else begin
        count_q <= count_eff - ONE;
      end
    end
  end

endmodule

// File: rtl/cdt_regs.sv
module cdt_regs
  import cdt_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  input  logic          expire,
  input  logic [DW-1:0] count_eff,
  output cdt_ctrl_t     ctrl_q,
  output logic [DW-1:0] load_q,
  output logic          load_now,
  output logic          pre_restart,
  output logic          raw_q,
  output logic [DW-1:0] rdata_q,
  output logic          irq_q
);

  logic      hit_load, hit_ctrl, hit_clr, hit_bg;
  cdt_ctrl_t ctrl_d;
  logic      raw_d;
  logic [DW-1:0] rd_mux;

  assign hit_load = we && (addr == AW'(OFS_LOAD));
  assign hit_ctrl = we && (addr == AW'(OFS_CTRL));
  assign hit_clr  = we && (addr == AW'(OFS_CLR));
  assign hit_bg   = we && (addr == AW'(OFS_BGLD));

  assign load_now    = hit_load;
  assign ctrl_d      = hit_ctrl ? cdt_ctrl_t'(wdata[7:0]) : ctrl_q;
  assign pre_restart = hit_ctrl && (wdata[3:2] != ctrl_q.pre);
  // An expiry in the same cycle as a clear keeps the flag.
  assign raw_d       = expire || (raw_q && !hit_clr);

  always_comb begin
    rd_mux = '0;
    if (addr == AW'(OFS_LOAD) || addr == AW'(OFS_BGLD)) begin
      rd_mux = load_q;
    end else if (addr == AW'(OFS_VALUE)) begin
      rd_mux = count_eff;
    end else if (addr == AW'(OFS_CTRL)) begin
      rd_mux = {{(DW-8){1'b0}}, ctrl_q};
    end else if (addr == AW'(OFS_RAW)) begin
      rd_mux = {{(DW-1){1'b0}}, raw_q};
    end else if (addr == AW'(OFS_MASK)) begin
      rd_mux = {{(DW-1){1'b0}}, raw_q && ctrl_q.ie};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= cdt_ctrl_t'(CTRL_RESET);
      load_q  <= '0;
      raw_q   <= 1'b0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      raw_q   <= raw_d;
      irq_q   <= raw_d && ctrl_d.ie;
      rdata_q <= rd_mux;
      if (hit_load || hit_bg) begin
        load_q <= wdata;
      end
    end
  end

endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AW    = 4,
  parameter int NW    = 16,
  parameter int PRE_W = 8,
  parameter int MID_W = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_o
);

  cdt_ctrl_t     ctrl_q;
  logic [DW-1:0] load_q;
  logic          load_now;
  logic          pre_restart;
  logic          raw_q;
  logic          tick;
  logic          expire;
  logic [DW-1:0] count_eff;

  cdt_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .addr        (bus_addr),
    .we          (bus_we),
    .wdata       (bus_wdata),
    .expire      (expire),
    .count_eff   (count_eff),
    .ctrl_q      (ctrl_q),
    .load_q      (load_q),
    .load_now    (load_now),
    .pre_restart (pre_restart),
    .raw_q       (raw_q),
    .rdata_q     (bus_rdata),
    .irq_q       (irq_o)
  );

  cdt_prescaler #(.PRE_W(PRE_W), .MID_W(MID_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .restart (pre_restart),
    .sel     (ctrl_q.pre),
    .tick    (tick)
  );

  cdt_counter #(.DW(DW), .NW(NW)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .en        (ctrl_q.en),
    .periodic  (ctrl_q.periodic),
    .oneshot   (ctrl_q.oneshot),
    .wide      (ctrl_q.wide),
    .tick      (tick),
    .load_now  (load_now),
    .load_data (bus_wdata),
    .load_val  (load_q),
    .count_eff (count_eff),
    .expire    (expire)
  );

endmodule

// File: rtl/cdt_checker.sv
module cdt_checker #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          we,
  input logic [AW-1:0] addr,
  input logic          irq_o,
  input logic          ie,
  input logic          en,
  input logic          oneshot,
  input logic          raw,
  input logic          expire,
  input logic [DW-1:0] count_eff
);

  logic wr_load, wr_ctrl, wr_clr, wr_value;
  assign wr_load  = we && (addr == AW'(0));
  assign wr_value = we && (addr == AW'(1));
  assign wr_ctrl  = we && (addr == AW'(2));
  assign wr_clr   = we && (addr == AW'(3));

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !ie |-> !irq_o);  // R10

  AST_IRQ_FOLLOWS_RAW: assert property (@(posedge clk) disable iff (rst)
    (raw && ie) |-> irq_o);  // R10

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
    (wr_clr && !expire) |=> !raw);  // R11

  AST_EXPIRE_HITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    expire |=> (count_eff == '0) && raw);  // R6

  AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (rst)
    (en && oneshot && count_eff == '0 && !wr_load && !wr_ctrl) |=> (count_eff == '0));  // R7

  AST_VALUE_READONLY: assert property (@(posedge clk) disable iff (rst)
    (wr_value && !en) |=> $stable(count_eff));  // R3

  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!en && !wr_load && !wr_ctrl) |=> $stable(count_eff));  // R12

endmodule

bind cdt_timer cdt_checker #(.DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .we        (bus_we),
  .addr      (bus_addr),
  .irq_o     (irq_o),
  .ie        (ctrl_q.ie),
  .en        (ctrl_q.en),
  .oneshot   (ctrl_q.oneshot),
  .raw       (raw_q),
  .expire    (expire),
  .count_eff (count_eff)
);

// File: tb/tb_cdt_timer.sv
module tb_cdt_timer;

  localparam int DW = 32;
  localparam int AW = 4;
  localparam int WAIT_LIMIT = 70000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  cdt_timer dut (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic wr(input int a, input logic [DW-1:0] d);
    bus_addr  = AW'(a);
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    bus_addr = AW'(a);
    bus_we   = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_irq(output int k);
    k = 0;
    while (!irq_o && k < WAIT_LIMIT) begin
      @(negedge clk);
      k++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    int k;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R2 reset state
    chk("R2 irq", {31'd0, irq_o}, 32'd0);
    rd(2, v); chk("R2 ctrl", v, 32'h20);
    rd(1, v); chk("R2 value", v, 32'hFFFF);
    rd(0, v); chk("R2 load", v, 32'h0);
    rd(4, v); chk("R2 raw", v, 32'h0);

    // R6 periodic sweep, prescale 1, 32-bit size
    for (int n = 1; n <= 6; n++) begin
      wr(2, 32'h62);
      wr(0, n);
      rd(1, v); chk("R4 immediate reload", v, n);
      wr(2, 32'hE2);
      wait_irq(k); chk("R6 first expiry", k, n);
      wr(3, 0);
      wait_irq(k); chk("R6 period", k, n);
      wr(2, 32'h62);
      wr(3, 0);
      chk("R11 clear", {31'd0, irq_o}, 32'd0);
    end

    // R12 disabled counter holds (reloaded to 6 before disable)
    rd(1, v); chk("R12 hold a", v, 6);
    rd(1, v); chk("R12 hold b", v, 6);

    // R3 value register read-only; R1 map and unmapped offsets
    wr(1, 0);
    rd(1, v); chk("R3 value write ignored", v, 6);
    wr(7, 32'hFFFF_FFFF);
    rd(7, v); chk("R1 unmapped 7", v, 0);
    rd(15, v); chk("R1 unmapped 15", v, 0);
    rd(3, v); chk("R1 clear offset reads 0", v, 0);
    rd(0, v); chk("R1 load after unmapped write", v, 6);
    rd(6, v); chk("R1 background offset reads load", v, 6);
    rd(2, v); chk("R1 ctrl after unmapped write", v, 32'h62);

    // R10 masked status
    wr(0, 3);
    wr(2, 32'hC2);
    repeat (10) @(negedge clk);
    chk("R10 irq masked", {31'd0, irq_o}, 0);
    rd(4, v); chk("R10 raw set", v, 1);
    rd(5, v); chk("R10 masked zero", v, 0);
    wr(2, 32'h62);
    chk("R10 irq after enable", {31'd0, irq_o}, 1);
    rd(5, v); chk("R10 masked one", v, 1);
    wr(3, 0);
    chk("R11 irq cleared", {31'd0, irq_o}, 0);
    rd(4, v); chk("R11 raw cleared", v, 0);

    // R7 one-shot
    wr(0, 3);
    wr(2, 32'hA3);
    wait_irq(k); chk("R7 oneshot expiry", k, 3);
    wr(3, 0);
    repeat (20) @(negedge clk);
    chk("R7 no second irq", {31'd0, irq_o}, 0);
    rd(4, v); chk("R7 raw stays clear", v, 0);
    rd(1, v); chk("R7 halted at zero", v, 0);
    wr(2, 32'h62);

    // R5 background load
    wr(0, 3);
    wr(2, 32'hE2);
    wr(6, 5);
    wait_irq(k); chk("R5 current period kept", k, 2);
    wr(3, 0);
    wait_irq(k); chk("R5 next period uses new value", k, 5);
    rd(0, v); chk("R5 load reads new value", v, 5);
    rd(6, v); chk("R5 background reads new value", v, 5);
    wr(2, 32'h62);
    wr(3, 0);

    // R9 prescale sweep
    for (int n = 1; n <= 3; n++) begin
      wr(0, n);
      wr(2, 32'hE6);
      wait_irq(k); chk("R9 divide by 16", k, 16 * n);
      wr(2, 32'h62);
      wr(3, 0);
    end
    wr(0, 1);
    wr(2, 32'hEA);
    wait_irq(k); chk("R9 divide by 256", k, 256);
    wr(2, 32'h62);
    wr(3, 0);
    wr(0, 4);
    wr(2, 32'hEE);
    wait_irq(k); chk("R9 code 3 divides by 1", k, 4);
    wr(2, 32'h62);
    wr(3, 0);

    // R8 free-running 16-bit, R4 load write reloads full size
    wr(2, 32'hA0);
    wr(0, 5);
    rd(1, v); chk("R8 load ignored, full reload", v, 32'hFFFF);
    rd(1, v); chk("R8 counting down", v, 32'hFFFE);
    wait_irq(k); chk("R8 16-bit wrap time", k, 65533);
    rd(1, v); chk("R8 reached zero", v, 0);
    rd(1, v); chk("R8 wraps to 0xFFFF", v, 32'hFFFF);
    rd(0, v); chk("R8 load kept", v, 5);
    wr(2, 32'hA2);
    wr(0, 7);
    rd(1, v); chk("R8 32-bit full reload", v, 32'hFFFF_FFFF);
    wr(2, 32'h22);
    wr(3, 0);
    chk("R11 final clear", {31'd0, irq_o}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule